// File: doc/BRIEF.md
# Word Serializer with Wrap-Back Path Select

This block turns a stream of already-encoded 10-bit code words into a serial bit stream. It runs in one synchronous domain on a single bit-rate clock. An internal phase counter divides that clock by the word width. Once per word period it raises a byte tick, and on that edge the parallel input word is captured into a holding register. A fixed number of bit times later the held word is loaded into a shift register. The shift register sends the word out one bit per clock, bit 0 first, with no gap between words.

A wrap control picks where the serial stream goes. When wrap is off, the stream drives the external serial output, and the receive-side select passes the external serial input through. When wrap is on, the external output is parked at logic 1 and the receive-side select carries the internal transmit stream. The wrap control is sampled only on the word-load edge, so a word never leaves partly on one path and partly on the other.

Top module: `sertx_loop`

## Requirements
- R1: The input word is captured only on a clock edge where `byte_tick` is high. Values on `word_in` at any other edge have no effect on the serial stream.
- R2: `byte_tick` is high for exactly one cycle in every WORD_W cycles. After reset release it first rises following edge WORD_W-1.
- R3: Bit 0 of a captured word appears on the serial stream TX_LAT clock edges after the edge that captured it. With the defaults, that is 4 bit times.
- R4: A word is sent least significant bit first, one bit per clock. The last bit of one word is followed directly by the first bit of the next.
- R5: After reset the serial stream is logic 1 until the first captured word is loaded.
- R6: With the sampled wrap select low (0), `ser_out` carries the serial stream and `rx_mux_out` equals `ext_rx_in`.
- R7: With the sampled wrap select high (1), `ser_out` is constant 1 and `rx_mux_out` carries the serial stream.
- R8: `wrap_en` is sampled only on the word-load edge, which is TX_LAT edges after a capture. The sampled value governs all WORD_W bits of the word loaded on that edge. Values at any other edge have no effect.
- R9: While reset is asserted, `byte_tick` is 0, `ser_out` is 1 and `rx_mux_out` follows `ext_rx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | WORD_W | Encoded code word to send |
| wrap_en | input | 1 | 1 routes the stream internally, 0 routes it out |
| ext_rx_in | input | 1 | External serial input for the receive side |
| byte_tick | output | 1 | High in the cycle whose closing edge captures `word_in` |
| ser_out | output | 1 | External serial output |
| rx_mux_out | output | 1 | Receive-side serial input after the path select |

## Verification
The bench sends every one of the 1024 code words back to back. Between capture edges it drives junk on `word_in`, so a design that captured on the wrong phase would mix junk into the bit stream. The wrap control also toggles at random between load edges. A design that sampled it mid-word would split that word across both outputs, or park `ser_out` high in the middle of a word. Bit-exact checks of the first bit after each capture catch a latency off by one, and checks across each word catch a reversed bit order. Checks just after reset catch an output that starts at 0 or sends the reset contents of the holding register before the first real word.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned DEF_WORD_W = 10;
  localparam int unsigned DEF_TX_LAT = 4;

  typedef enum logic {
    PATH_EXT  = 1'b0,
    PATH_WRAP = 1'b1
  } path_e;
endpackage

// File: rtl/sertx_phase.sv
module sertx_phase #(
  parameter int unsigned WORD_W = sertx_pkg::DEF_WORD_W,
  parameter int unsigned TX_LAT = sertx_pkg::DEF_TX_LAT
) (
  input  logic clk,
  input  logic rst_n,
  output logic cap_o,
  output logic load_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LOAD_PH = CNT_W'(TX_LAT - 1);

  logic [CNT_W-1:0] ph_q, ph_d;

  always_comb begin
    if (ph_q == LAST_PH) ph_d = '0;
    else                 ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign cap_o  = (ph_q == LAST_PH);
  assign load_o = (ph_q == LOAD_PH);

  a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> !cap_o);
  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST_PH);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned WORD_W = sertx_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] hold_o
);
  logic [WORD_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (cap_i) hold_d = word_i;
  end

  // reset to all ones so an early load keeps the line idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '1;
    else        hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(hold_q));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int unsigned WORD_W = sertx_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] hold_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    if (load_i) sh_d = hold_i;
    else        sh_d = {1'b1, sh_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign bit_o = sh_q[0];

  a_r3_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> bit_o == $past(hold_i[0]));
endmodule

// File: rtl/sertx_route.sv
module sertx_route
  import sertx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic wrap_i,
  input  logic tx_bit_i,
  input  logic ext_rx_i,
  output logic ser_o,
  output logic rx_o
);
  path_e path_q, path_d;

  always_comb begin
    path_d = path_q;
    if (load_i) path_d = wrap_i ? PATH_WRAP : PATH_EXT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) path_q <= PATH_EXT;
    else        path_q <= path_d;
  end

  always_comb begin
    if (path_q == PATH_WRAP) begin
      ser_o = 1'b1;
      rx_o  = tx_bit_i;
    end else begin
      ser_o = tx_bit_i;
      rx_o  = ext_rx_i;
    end
  end

  a_r8_sel_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(path_q));
endmodule

// File: rtl/sertx_loop.sv
module sertx_loop #(
  parameter int unsigned WORD_W = sertx_pkg::DEF_WORD_W,
  parameter int unsigned TX_LAT = sertx_pkg::DEF_TX_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              wrap_en,
  input  logic              ext_rx_in,
  output logic              byte_tick,
  output logic              ser_out,
  output logic              rx_mux_out
);
  logic              cap, load, tx_bit;
  logic [WORD_W-1:0] hold;

  sertx_phase #(.WORD_W(WORD_W), .TX_LAT(TX_LAT)) u_phase (
    .clk(clk), .rst_n(rst_n), .cap_o(cap), .load_o(load));

  sertx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .word_i(word_in), .hold_o(hold));

  sertx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .hold_i(hold), .bit_o(tx_bit));

  sertx_route u_route (
    .clk(clk), .rst_n(rst_n), .load_i(load), .wrap_i(wrap_en),
    .tx_bit_i(tx_bit), .ext_rx_i(ext_rx_in), .ser_o(ser_out), .rx_o(rx_mux_out));

  assign byte_tick = cap;

  a_r7_wrap_parks_out: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out == 1'b0) |-> (rx_mux_out == ext_rx_in));
endmodule

// File: tb/test_sertx_loop.sv
module test_sertx_loop;
  localparam int W   = 10;
  localparam int LAT = 4;
  localparam int NW  = 1026;
  localparam int NE  = W * (NW - 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] word_in;
  logic wrap_en, ext_rx_in;
  logic byte_tick, ser_out, rx_mux_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [W-1:0] words [0:NW-1];
  logic         wraps [0:NW-1];

  always #2 clk = ~clk;

  sertx_loop #(.WORD_W(W), .TX_LAT(LAT)) i_sertx_loop (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .wrap_en(wrap_en),
    .ext_rx_in(ext_rx_in), .byte_tick(byte_tick), .ser_out(ser_out),
    .rx_mux_out(rx_mux_out));

  task automatic check(input string req, input int n, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: actual %b expected %b", req, n, act, exp);
    end
  endtask

  // inputs for edge k: junk except on the capture/load edges
  task automatic drive(input int k);
    word_in   = (k % W == 0) ? words[k / W] : W'($urandom);
    wrap_en   = (k >= LAT && (k - LAT) % W == 0) ? wraps[(k - LAT) / W] : 1'($urandom);
    ext_rx_in = 1'($urandom);
  endtask

  initial begin
    words[0] = '1;
    wraps[0] = 1'b0;
    for (int m = 1; m < NW; m++) begin
      words[m] = (m <= 1024) ? W'(m - 1) : W'($urandom);
      wraps[m] = ((m % 5) == 2) || (((m / 100) % 2) == 1);
    end
    rst_n = 1'b0;
    drive(1);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", 0, byte_tick, 1'b0);
    check("R9", 0, ser_out, 1'b1);
    check("R9", 0, rx_mux_out, ext_rx_in);
    rst_n = 1'b1;
    for (int n = 1; n <= NE; n++) begin
      logic ext_now, stream, wq;
      int   m, i;
      ext_now = ext_rx_in;
      @(posedge clk);
      @(negedge clk);
      check("R2", n, byte_tick, (n % W == W - 1));
      if (n < LAT) begin
        stream = 1'b1; wq = 1'b0; m = 0; i = 0;
      end else begin
        m = (n - LAT) / W;
        i = (n - LAT) % W;
        stream = words[m][i];
        wq = wraps[m];
      end
      if (m == 0)
        check("R5", n, ser_out, 1'b1);
      else if (wq) begin
        check("R7", n, ser_out, 1'b1);
        check("R7", n, rx_mux_out, stream);
      end else begin
        check(i == 0 ? "R3" : "R1 R4", n, ser_out, stream);
        check("R6", n, rx_mux_out, ext_now);
      end
      if (m > 0 && i == 0 && wraps[m] != wraps[m-1])
        check("R8", n, wq ? rx_mux_out : ser_out, stream);
      drive(n + 1);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule